// File: doc/BRIEF.md
# Accumulator ALU with Decimal Adjust

This block is the arithmetic and logic unit of an accumulator-oriented 8-bit microcontroller datapath. It is purely combinational. Each cycle the surrounding pipeline presents an operation code, the accumulator byte, a second operand byte (a register, a memory byte or an immediate, already fetched elsewhere), and the current carry, auxiliary-carry and overflow flags. The block returns the new accumulator byte, the new operand byte, and the three flags as they should be written back.

The operation set covers binary addition with and without carry-in, subtraction that always takes the borrow, increment and decrement, bitwise AND, OR and XOR, clear and complement, plain and carry-through rotates in both directions, a nibble swap, an exchange of the low nibbles of the accumulator and the operand, and a BCD correction step that follows a binary add of two packed BCD bytes. A flag that an operation does not define is passed through unchanged. The new operand output lets the caller write the operand location back for the low-nibble exchange. For every other code it simply echoes the operand input.

Top module: `acc_alu`

## Requirements
- R1: Op code 0 (add): `{cy_o, acc_o}` equals `acc_i + opnd_i` as a 9-bit sum. The incoming `cy_i` has no effect.
- R2: Op code 1 (add with carry): `{cy_o, acc_o}` equals `acc_i + opnd_i + cy_i` as a 9-bit sum.
- R3: Op code 2 (subtract with borrow): `acc_o` equals `acc_i - opnd_i - cy_i` modulo 256. `cy_o` is 1 exactly when that difference is negative as an unsigned number.
- R4: For op codes 0, 1 and 2, `ac_o` is the carry out of bit 3 when adding, or the borrow into bit 4 of the low-nibble difference when subtracting.
- R5: For op codes 0, 1 and 2, `ov_o` is 1 exactly when the result interpreted as two's complement lies outside -128..127.
- R6: Op code 3 (increment) and op code 4 (decrement) wrap modulo 256 and pass `cy_i`, `ac_i` and `ov_i` through unchanged.
- R7: Op codes 5, 6, 7, 8 and 9 give AND, OR and XOR with the operand, zero, and the bitwise complement of the accumulator, in that order. All flags pass through.
- R8: Op code 10 rotates the accumulator left by one and op code 12 rotates it right by one, over 8 bits only. All flags pass through.
- R9: Op code 11 rotates the 9-bit value `{cy, acc}` left and op code 13 rotates it right. The bit shifted out of the accumulator becomes `cy_o`.
- R10: Op code 14 exchanges bits 7:4 and bits 3:0 of the accumulator. Flags pass through.
- R11: Op code 15 exchanges bits 3:0 of the accumulator with bits 3:0 of the operand. The upper nibbles of both stay put, and `opnd_o` carries the new operand byte. For every other op code, `opnd_o` equals `opnd_i`.
- R12: Op code 16 (decimal adjust), low step: when `acc_i[3:0]` is above 9 or `ac_i` is 1, 06h is added to the whole byte.
- R13: Op code 16, high step: when bits 7:4 after the low step are above 9, or the carry is 1, 60h is added. `cy_o` is set if either step carries out of bit 7, and it is never cleared when `cy_i` is 1. AC and OV pass through.
- R14: Op codes 17 to 31 are undefined. For these, `acc_o` equals `acc_i`, `opnd_o` equals `opnd_i`, and all flags pass through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 5 | Operation code |
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Second operand byte |
| cy_i | input | 1 | Current carry flag |
| ac_i | input | 1 | Current auxiliary-carry flag |
| ov_i | input | 1 | Current overflow flag |
| acc_o | output | 8 | New accumulator value |
| opnd_o | output | 8 | New operand byte, for write-back |
| cy_o | output | 1 | New carry flag |
| ac_o | output | 1 | New auxiliary-carry flag |
| ov_o | output | 1 | New overflow flag |

## Verification
The bound checker runs every time the inputs change. It checks the following relations:
- the 9-bit sums of the two add forms and the wrapped subtraction;
- that the flags are kept by increment, decrement, the logic operations and the plain rotates;
- where the carry-through rotates take `cy_o` from;
- the nibble placement of the swap and of the low-nibble exchange;
- that decimal adjust never drops a set carry;
- that undefined codes pass everything through.

The exact auxiliary-carry and overflow values on subtraction, and the full two-step BCD correction (including the low-step carry rippling into the high nibble), are shown only by the bench. Its reference model covers the boundary bytes 7Fh, 80h, FFh and 9Ah, plus several thousand random operations over all 32 codes.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   localparam int OP_W = 5;

   typedef enum logic [OP_W-1:0] {
      ALU_ADD  = 5'd0,
      ALU_ADDC = 5'd1,
      ALU_SUBB = 5'd2,
      ALU_INC  = 5'd3,
      ALU_DEC  = 5'd4,
      ALU_AND  = 5'd5,
      ALU_OR   = 5'd6,
      ALU_XOR  = 5'd7,
      ALU_CLR  = 5'd8,
      ALU_CPL  = 5'd9,
      ALU_RL   = 5'd10,
      ALU_RLC  = 5'd11,
      ALU_RR   = 5'd12,
      ALU_RRC  = 5'd13,
      ALU_SWAP = 5'd14,
      ALU_XCHD = 5'd15,
      ALU_DA   = 5'd16
   } alu_op_e;

endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              cin_i,
   input  logic              sub_i,
   output logic [DATA_W-1:0] sum_o,
   output logic              cy_o,
   output logic              ac_o,
   output logic              ov_o
);
   localparam int NIB_W = DATA_W / 2;

   logic [DATA_W-1:0] b_x;
   logic              c_in;
   logic [NIB_W:0]    lo_sum;
   logic [DATA_W-1:0] top_in;
   logic [DATA_W:0]   full;

   // Subtraction as a + ~b + ~borrow; carries are inverted back to borrows.
   assign b_x  = sub_i ? ~b_i : b_i;
   assign c_in = sub_i ? ~cin_i : cin_i;

   assign lo_sum = {1'b0, a_i[NIB_W-1:0]} + {1'b0, b_x[NIB_W-1:0]}
                 + {{NIB_W{1'b0}}, c_in};
   assign top_in = {1'b0, a_i[DATA_W-2:0]} + {1'b0, b_x[DATA_W-2:0]}
                 + {{(DATA_W-1){1'b0}}, c_in};
   assign full   = {1'b0, a_i} + {1'b0, b_x} + {{DATA_W{1'b0}}, c_in};

   assign sum_o = full[DATA_W-1:0];
   assign cy_o  = full[DATA_W] ^ sub_i;
   assign ac_o  = lo_sum[NIB_W] ^ sub_i;
   assign ov_o  = top_in[DATA_W-1] ^ full[DATA_W];

endmodule

// File: rtl/acc_alu_rot.sv
module acc_alu_rot #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              cy_i,
   output logic [DATA_W-1:0] rl_o,
   output logic [DATA_W-1:0] rr_o,
   output logic [DATA_W-1:0] rlc_o,
   output logic              rlc_cy_o,
   output logic [DATA_W-1:0] rrc_o,
   output logic              rrc_cy_o,
   output logic [DATA_W-1:0] swap_o,
   output logic [DATA_W-1:0] xchd_a_o,
   output logic [DATA_W-1:0] xchd_b_o
);
   localparam int NIB_W = DATA_W / 2;

   assign rl_o     = {a_i[DATA_W-2:0], a_i[DATA_W-1]};
   assign rr_o     = {a_i[0], a_i[DATA_W-1:1]};
   assign rlc_o    = {a_i[DATA_W-2:0], cy_i};
   assign rlc_cy_o = a_i[DATA_W-1];
   assign rrc_o    = {cy_i, a_i[DATA_W-1:1]};
   assign rrc_cy_o = a_i[0];

   genvar g;
   generate
      for (g = 0; g < NIB_W; g++) begin : g_nib
         assign swap_o[g]         = a_i[g+NIB_W];
         assign swap_o[g+NIB_W]   = a_i[g];
         assign xchd_a_o[g]       = b_i[g];
         assign xchd_a_o[g+NIB_W] = a_i[g+NIB_W];
         assign xchd_b_o[g]       = a_i[g];
         assign xchd_b_o[g+NIB_W] = b_i[g+NIB_W];
      end
   endgenerate

endmodule

// File: rtl/acc_alu_dadj.sv
module acc_alu_dadj #(
   parameter int DATA_W = 8,
   parameter bit EN     = 1'b1
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic              cy_i,
   input  logic              ac_i,
   output logic [DATA_W-1:0] res_o,
   output logic              cy_o
);
   localparam int NIB_W = DATA_W / 2;

   generate
      if (EN) begin : g_bcd
         if (NIB_W != 4) begin : g_bad_nib
            $error("acc_alu_dadj: decimal adjust needs 4-bit digits");
         end
         localparam logic [NIB_W-1:0] DIG_MAX = NIB_W'(9);
         localparam logic [DATA_W:0]  ADJ_LO  = (DATA_W+1)'(6);
         localparam logic [DATA_W:0]  ADJ_HI  = ADJ_LO << NIB_W;

         logic            lo_fix, hi_fix, c_mid;
         logic [DATA_W:0] step1, step2;

         assign lo_fix = (a_i[NIB_W-1:0] > DIG_MAX) || ac_i;
         assign step1  = {1'b0, a_i} + (lo_fix ? ADJ_LO : '0);
         assign c_mid  = cy_i | step1[DATA_W];
         assign hi_fix = (step1[DATA_W-1:NIB_W] > DIG_MAX) || c_mid;
         assign step2  = {1'b0, step1[DATA_W-1:0]} + (hi_fix ? ADJ_HI : '0);
         assign res_o  = step2[DATA_W-1:0];
         assign cy_o   = c_mid | step2[DATA_W];
      end else begin : g_none
         logic unused_ac;
         assign unused_ac = ac_i;
         assign res_o     = a_i;
         assign cy_o      = cy_i;
      end
   endgenerate

endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_alu_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter bit DA_EN  = 1'b1
) (
   input  logic [OP_W-1:0]   op_i,
   input  logic [DATA_W-1:0] acc_i,
   input  logic [DATA_W-1:0] opnd_i,
   input  logic              cy_i,
   input  logic              ac_i,
   input  logic              ov_i,
   output logic [DATA_W-1:0] acc_o,
   output logic [DATA_W-1:0] opnd_o,
   output logic              cy_o,
   output logic              ac_o,
   output logic              ov_o
);
   localparam int NIB_W = DATA_W / 2;

   generate
      if ((DATA_W % 2) != 0 || DATA_W < 4) begin : g_bad_width
         $error("acc_alu: DATA_W must be even and at least 4");
      end
   endgenerate

   logic              is_sub, is_addc;
   logic              as_cin;
   logic [DATA_W-1:0] as_sum;
   logic              as_cy, as_ac, as_ov;

   assign is_sub  = (op_i == ALU_SUBB);
   assign is_addc = (op_i == ALU_ADDC);
   assign as_cin  = (is_sub || is_addc) ? cy_i : 1'b0;

   acc_alu_addsub #(.DATA_W(DATA_W)) u_addsub (
      .a_i   (acc_i),
      .b_i   (opnd_i),
      .cin_i (as_cin),
      .sub_i (is_sub),
      .sum_o (as_sum),
      .cy_o  (as_cy),
      .ac_o  (as_ac),
      .ov_o  (as_ov)
   );

   logic [DATA_W-1:0] rl_v, rr_v, rlc_v, rrc_v, swap_v, xa_v, xb_v;
   logic              rlc_c, rrc_c;

   acc_alu_rot #(.DATA_W(DATA_W)) u_rot (
      .a_i      (acc_i),
      .b_i      (opnd_i),
      .cy_i     (cy_i),
      .rl_o     (rl_v),
      .rr_o     (rr_v),
      .rlc_o    (rlc_v),
      .rlc_cy_o (rlc_c),
      .rrc_o    (rrc_v),
      .rrc_cy_o (rrc_c),
      .swap_o   (swap_v),
      .xchd_a_o (xa_v),
      .xchd_b_o (xb_v)
   );

   logic [DATA_W-1:0] da_v;
   logic              da_c;

   acc_alu_dadj #(.DATA_W(DATA_W), .EN(DA_EN)) u_dadj (
      .a_i   (acc_i),
      .cy_i  (cy_i),
      .ac_i  (ac_i),
      .res_o (da_v),
      .cy_o  (da_c)
   );

   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

   always_comb begin
      acc_o  = acc_i;
      opnd_o = opnd_i;
      cy_o   = cy_i;
      ac_o   = ac_i;
      ov_o   = ov_i;
      case (op_i)
         ALU_ADD, ALU_ADDC, ALU_SUBB: begin
            acc_o = as_sum;
            cy_o  = as_cy;
            ac_o  = as_ac;
            ov_o  = as_ov;
         end
         ALU_INC:  acc_o = acc_i + ONE;
         ALU_DEC:  acc_o = acc_i - ONE;
         ALU_AND:  acc_o = acc_i & opnd_i;
         ALU_OR:   acc_o = acc_i | opnd_i;
         ALU_XOR:  acc_o = acc_i ^ opnd_i;
         ALU_CLR:  acc_o = '0;
         ALU_CPL:  acc_o = ~acc_i;
         ALU_RL:   acc_o = rl_v;
         ALU_RR:   acc_o = rr_v;
         ALU_RLC: begin
            acc_o = rlc_v;
            cy_o  = rlc_c;
         end
         ALU_RRC: begin
            acc_o = rrc_v;
            cy_o  = rrc_c;
         end
         ALU_SWAP: acc_o = swap_v;
         ALU_XCHD: begin
            acc_o  = xa_v;
            opnd_o = xb_v;
         end
         ALU_DA: begin
            acc_o = da_v;
            cy_o  = da_c;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
   import acc_alu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input logic [OP_W-1:0]   op_i,
   input logic [DATA_W-1:0] acc_i,
   input logic [DATA_W-1:0] opnd_i,
   input logic              cy_i,
   input logic              ac_i,
   input logic              ov_i,
   input logic [DATA_W-1:0] acc_o,
   input logic [DATA_W-1:0] opnd_o,
   input logic              cy_o,
   input logic              ac_o,
   input logic              ov_o
);
   localparam int NIB_W = DATA_W / 2;

   logic flags_kept;
   assign flags_kept = (cy_o == cy_i) && (ac_o == ac_i) && (ov_o == ov_i);

   always_comb begin
      if (op_i == ALU_ADD)
         p_add_ignores_cy_r1: assert ({cy_o, acc_o} == ({1'b0, acc_i} + {1'b0, opnd_i}))
            else $error("R1 add sum mismatch");
      if (op_i == ALU_ADDC)
         p_addc_sum_r2: assert ({cy_o, acc_o} == ({1'b0, acc_i} + {1'b0, opnd_i}
                                                  + {{DATA_W{1'b0}}, cy_i}))
            else $error("R2 add-with-carry mismatch");
      if (op_i == ALU_SUBB)
         p_subb_wrap_r3: assert (acc_o == (acc_i - opnd_i - {{(DATA_W-1){1'b0}}, cy_i}))
            else $error("R3 subtract mismatch");
      if (op_i == ALU_INC || op_i == ALU_DEC)
         p_incdec_flags_r6: assert (flags_kept) else $error("R6 flags changed");
      if (op_i >= ALU_AND && op_i <= ALU_CPL)
         p_logic_flags_r7: assert (flags_kept) else $error("R7 flags changed");
      if (op_i == ALU_RL || op_i == ALU_RR)
         p_rot8_r8: assert (flags_kept && ($countones(acc_o) == $countones(acc_i)))
            else $error("R8 plain rotate broken");
      if (op_i == ALU_RLC)
         p_rlc_cy_r9: assert (cy_o == acc_i[DATA_W-1] && acc_o[0] == cy_i)
            else $error("R9 rotate-left through carry broken");
      if (op_i == ALU_RRC)
         p_rrc_cy_r9: assert (cy_o == acc_i[0] && acc_o[DATA_W-1] == cy_i)
            else $error("R9 rotate-right through carry broken");
      if (op_i == ALU_SWAP)
         p_swap_r10: assert (acc_o[NIB_W-1:0] == acc_i[DATA_W-1:NIB_W]
                             && acc_o[DATA_W-1:NIB_W] == acc_i[NIB_W-1:0] && flags_kept)
            else $error("R10 swap broken");
      if (op_i == ALU_XCHD)
         p_xchd_r11: assert (acc_o[DATA_W-1:NIB_W] == acc_i[DATA_W-1:NIB_W]
                             && opnd_o[DATA_W-1:NIB_W] == opnd_i[DATA_W-1:NIB_W]
                             && acc_o[NIB_W-1:0] == opnd_i[NIB_W-1:0]
                             && opnd_o[NIB_W-1:0] == acc_i[NIB_W-1:0])
            else $error("R11 nibble exchange broken");
      else
         p_opnd_echo_r11: assert (opnd_o == opnd_i) else $error("R11 operand altered");
      if (op_i == ALU_DA)
         p_da_keeps_cy_r13: assert ((!cy_i || cy_o) && ac_o == ac_i && ov_o == ov_i)
            else $error("R13 decimal adjust flag rule broken");
      if (op_i > ALU_DA)
         p_undef_pass_r14: assert (acc_o == acc_i && flags_kept)
            else $error("R14 undefined code changed state");
   end

endmodule

bind acc_alu acc_alu_chk #(.DATA_W(DATA_W)) u_chk (
   .op_i   (op_i),
   .acc_i  (acc_i),
   .opnd_i (opnd_i),
   .cy_i   (cy_i),
   .ac_i   (ac_i),
   .ov_i   (ov_i),
   .acc_o  (acc_o),
   .opnd_o (opnd_o),
   .cy_o   (cy_o),
   .ac_o   (ac_o),
   .ov_o   (ov_o)
);

// File: tb/tb_acc_alu.sv
module tb_acc_alu;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [4:0] op_i = '0;
   logic [7:0] acc_i = '0, opnd_i = '0;
   logic       cy_i = 1'b0, ac_i = 1'b0, ov_i = 1'b0;
   logic [7:0] acc_o, opnd_o;
   logic       cy_o, ac_o, ov_o;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   acc_alu dut (
      .op_i(op_i), .acc_i(acc_i), .opnd_i(opnd_i),
      .cy_i(cy_i), .ac_i(ac_i), .ov_i(ov_i),
      .acc_o(acc_o), .opnd_o(opnd_o),
      .cy_o(cy_o), .ac_o(ac_o), .ov_o(ov_o)
   );

   function automatic string tag_of(input int op);
      case (op)
         0: return "R1";   1: return "R2";   2: return "R3";
         3, 4: return "R6";
         5, 6, 7, 8, 9: return "R7";
         10, 12: return "R8";
         11, 13: return "R9";
         14: return "R10";
         15: return "R11";
         16: return "R12";
         default: return "R14";
      endcase
   endfunction

   function automatic int sgn(input int v);
      return (v >= 128) ? v - 256 : v;
   endfunction

   // Behavioural reference, integer arithmetic.
   task automatic model(input int op, a, b, cy, ac, ov,
                        output int r, ob, c, h, v);
      int s, t;
      r = a; ob = b; c = cy; h = ac; v = ov;
      case (op)
         0, 1: begin
            t = (op == 1) ? cy : 0;
            s = a + b + t;
            r = s % 256; c = (s > 255);
            h = ((a % 16) + (b % 16) + t) > 15;
            s = sgn(a) + sgn(b) + t;
            v = (s > 127 || s < -128);
         end
         2: begin
            s = a - b - cy;
            r = (s + 512) % 256; c = (s < 0);
            h = ((a % 16) - (b % 16) - cy) < 0;
            s = sgn(a) - sgn(b) - cy;
            v = (s > 127 || s < -128);
         end
         3: r = (a + 1) % 256;
         4: r = (a + 255) % 256;
         5: r = a & b;
         6: r = a | b;
         7: r = a ^ b;
         8: r = 0;
         9: r = 255 - a;
         10: r = ((a * 2) % 256) + (a / 128);
         11: begin r = ((a * 2) % 256) + cy; c = a / 128; end
         12: r = (a / 2) + ((a % 2) * 128);
         13: begin r = (a / 2) + cy * 128; c = a % 2; end
         14: r = ((a % 16) * 16) + (a / 16);
         15: begin r = (a / 16) * 16 + (b % 16); ob = (b / 16) * 16 + (a % 16); end
         16: begin
            t = a;
            if ((t % 16) > 9 || ac) t = t + 6;
            if (t > 255) c = 1;
            t = t % 256;
            if ((t / 16) > 9 || c) t = t + 96;
            if (t > 255) c = 1;
            r = t % 256;
         end
         default: ;
      endcase
   endtask

   task automatic cmp(input string tag, input string what, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h (op=%0d a=%0h b=%0h cy=%0b ac=%0b)",
                  tag, what, act, exp, op_i, acc_i, opnd_i, cy_i, ac_i);
      end
   endtask

   task automatic run(input int op, a, b, cy, ac, ov);
      int r, ob, c, h, v;
      string t;
      @(posedge clk);
      #1;
      op_i = op[4:0]; acc_i = a[7:0]; opnd_i = b[7:0];
      cy_i = cy[0]; ac_i = ac[0]; ov_i = ov[0];
      model(op, a, b, cy, ac, ov, r, ob, c, h, v);
      @(negedge clk);
      t = tag_of(op);
      cmp(t, "acc", int'(acc_o), r);
      cmp((op == 15) ? "R11" : t, "opnd", int'(opnd_o), ob);
      cmp((op == 16) ? "R13" : t, "cy", int'(cy_o), c);
      cmp((op <= 2) ? "R4" : t, "ac", int'(ac_o), h);
      cmp((op <= 2) ? "R5" : t, "ov", int'(ov_o), v);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog all-requirements actual=timeout expected=finish");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // Idle state with all-zero inputs: add of 0+0 (R1).
      cmp("R1", "idle acc", int'(acc_o), 0);
      cmp("R1", "idle cy", int'(cy_o), 0);
      rst = 1'b0;

      run(0, 8'h7F, 8'h01, 1, 0, 0);   // R1 signed overflow, cy ignored
      run(0, 8'hFF, 8'h01, 0, 0, 0);   // R1 carry out, R4 half carry
      run(0, 8'h0F, 8'h01, 0, 0, 1);   // R4 half carry, R5 clears ov
      run(1, 8'hFF, 8'h00, 1, 0, 0);   // R2 carry-in ripples out
      run(1, 8'h3C, 8'h44, 1, 0, 0);   // R2
      run(2, 8'h00, 8'h00, 1, 0, 0);   // R3 borrow only, R4 low borrow
      run(2, 8'h80, 8'h01, 0, 0, 0);   // R3, R5 negative overflow
      run(2, 8'h7F, 8'hFF, 0, 0, 0);   // R5 positive overflow
      run(2, 8'h10, 8'h01, 0, 1, 0);   // R4 borrow from bit 4
      run(3, 8'hFF, 8'h00, 1, 1, 1);   // R6 wrap, flags kept
      run(4, 8'h00, 8'h00, 0, 1, 0);   // R6 wrap down
      run(5, 8'hF0, 8'h3C, 1, 0, 1);   // R7
      run(6, 8'hF0, 8'h0C, 0, 1, 0);   // R7
      run(7, 8'hAA, 8'hFF, 1, 1, 1);   // R7
      run(8, 8'h5A, 8'h00, 1, 0, 0);   // R7
      run(9, 8'h5A, 8'h00, 0, 0, 1);   // R7
      run(10, 8'h81, 8'h00, 0, 0, 0);  // R8
      run(12, 8'h01, 8'h00, 1, 0, 0);  // R8
      run(11, 8'h80, 8'h00, 0, 0, 0);  // R9
      run(13, 8'h01, 8'h00, 1, 0, 0);  // R9
      run(14, 8'hA5, 8'h00, 0, 1, 0);  // R10
      run(15, 8'h12, 8'h34, 1, 0, 1);  // R11
      run(16, 8'h9A, 8'h00, 0, 0, 0);  // R12 and R13: 00h with carry
      run(16, 8'h15, 8'h00, 0, 1, 0);  // R12 forced by AC
      run(16, 8'h22, 8'h00, 1, 0, 1);  // R13 carry kept
      run(16, 8'h99, 8'h00, 0, 0, 0);  // R12 nothing to adjust
      run(16, 8'hFA, 8'h00, 0, 0, 0);  // R12 low step carries out
      run(17, 8'h5C, 8'h3D, 1, 0, 1);  // R14
      run(31, 8'hC3, 8'h11, 0, 1, 0);  // R14

      for (int i = 0; i < 4000; i++) begin
         run(int'($urandom_range(31)), int'($urandom_range(255)), int'($urandom_range(255)),
             int'($urandom_range(1)), int'($urandom_range(1)), int'($urandom_range(1)));
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule